// File: doc/BRIEF.md
# Flash Descriptor Boot Loader

This block runs once after reset, and again on each restart. It pulls the first words of the boot flash image through a word-read port and checks that the image carries the descriptor signature. It then copies the base pointer words of three descriptor sections into output registers: component, region and access-control. Downstream logic waits for `desc_valid` before it trusts those registers.

The controller that owns this block cannot operate without a descriptor. A wrong signature is therefore terminal. The block raises `halt` with `halt_bad_sig`, issues no further reads, and stays there until reset or `restart`.

A read offset that lies outside the 4 KB descriptor window is a configuration fault. It also halts the block, with `halt_range` set, and no read is issued for it.

The read request channel is valid/ready. `rd_req_valid` and `rd_req_addr` stay constant until a cycle where `rd_req_ready` is high, and the request is taken on that cycle. At most one read is outstanding at a time. The response channel has no back-pressure. The block takes `rd_rsp_data` in any cycle where `rd_rsp_valid` is high while it is waiting on a read, and it ignores responses at all other times.

Top module: `fdesc_loader`

## Requirements
- R1: While `rst_n` is low, `rd_req_valid`, `desc_valid`, `halt`, `halt_bad_sig` and `halt_range` are low, and all three base outputs are zero.
- R2: Reads are issued strictly in this byte-offset order: 0x10 (signature), 0x30 (component base), 0x40 (region base), 0x80 (access-control base). A new request is raised only after the response to the previous one has arrived, so at most one read is outstanding.
- R3: While `rd_req_valid` is high and `rd_req_ready` is low, the request and its address hold unchanged in the next cycle.
- R4: If the word read at 0x10 equals 0x0FF0A55A, loading continues. Any other value sets `halt` and `halt_bad_sig`. After that, no request is issued until reset or `restart`.
- R5: The responses to the 0x30, 0x40 and 0x80 reads appear unchanged on `comp_base`, `regn_base` and `ctrl_base` respectively.
- R6: `desc_valid` rises only once all three base outputs hold their fetched words. It is never high together with `halt`, and it stays high until reset or `restart`.
- R7: If the next offset in the sequence is 4096 or more, the block sets `halt` and `halt_range` without issuing that read. Words fetched before that point stay on their outputs.
- R8: A `restart` pulse clears `desc_valid`, `halt`, both halt causes and all base outputs in the following cycle. Loading then starts again from the signature read.
- R9: A response that arrives while no read is outstanding has no effect on the outputs or on the read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Synchronous restart of the load |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W (24) | Byte offset of the requested word |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | DATA_W (32) | Read data word |
| desc_valid | output | 1 | Descriptor loaded and valid |
| halt | output | 1 | Fatal stop |
| halt_bad_sig | output | 1 | Halt cause: signature mismatch |
| halt_range | output | 1 | Halt cause: offset outside descriptor window |
| comp_base | output | DATA_W (32) | Component section base word |
| regn_base | output | DATA_W (32) | Region section base word |
| ctrl_base | output | DATA_W (32) | Access-control section base word |

## Verification
The bench holds the request channel stalled while it injects stray responses. A design that does not hold its request would show a changing address. A design that accepts data outside a pending read would latch garbage or skip the signature.

It tries a signature that differs only in its lowest bit, which catches a partial compare. It then keeps watching after the halt, which exposes a design that keeps reading.

It restarts a load midway and expects cleared outputs and a fresh sequence from 0x10. A design that resumes or keeps stale bases would fail this. A second instance with the last offset moved to 4096 must halt on range with the first two words kept and no out-of-window read.

// File: rtl/fdesc_pkg.sv
package fdesc_pkg;
  localparam int unsigned NUM_SECT  = 3;
  localparam int unsigned NUM_STEPS = NUM_SECT + 1;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE,
    ST_HALT
  } ld_state_e;
endpackage

// File: rtl/fdesc_step_map.sv
module fdesc_step_map
  import fdesc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DESC_LIMIT = 4096,
  parameter int unsigned SIG_OFS    = 16,
  parameter int unsigned COMP_OFS   = 48,
  parameter int unsigned REGN_OFS   = 64,
  parameter int unsigned CTRL_OFS   = 128
) (
  input  logic [STEP_W-1:0] step,
  output logic [ADDR_W-1:0] addr,
  output logic              beyond
);
  localparam int unsigned OFS_TAB [NUM_STEPS] = '{SIG_OFS, COMP_OFS, REGN_OFS, CTRL_OFS};

  logic [NUM_STEPS-1:0][ADDR_W-1:0] addr_tab;
  logic [NUM_STEPS-1:0]             beyond_tab;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step
    assign addr_tab[g]   = ADDR_W'(OFS_TAB[g]);
    assign beyond_tab[g] = (OFS_TAB[g] >= DESC_LIMIT);
  end

  assign addr   = addr_tab[step];
  assign beyond = beyond_tab[step];
endmodule

// File: rtl/fdesc_word_bank.sv
module fdesc_word_bank
  import fdesc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clear,
  input  logic                             cap_en,
  input  logic [STEP_W-1:0]                cap_sel,
  input  logic [DATA_W-1:0]                cap_data,
  output logic [NUM_SECT-1:0][DATA_W-1:0]  words
);
  for (genvar g = 0; g < NUM_SECT; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        words[g] <= '0;
      end else if (cap_en && (cap_sel == STEP_W'(g))) begin
        words[g] <= cap_data;
      end
    end
  end
endmodule

// File: rtl/fdesc_loader.sv
module fdesc_loader
  import fdesc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DESC_LIMIT = 4096,
  parameter int unsigned SIG_OFS    = 16,
  parameter int unsigned COMP_OFS   = 48,
  parameter int unsigned REGN_OFS   = 64,
  parameter int unsigned CTRL_OFS   = 128,
  parameter logic [31:0] SIG_WORD   = 32'h0FF0_A55A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              desc_valid,
  output logic              halt,
  output logic              halt_bad_sig,
  output logic              halt_range,
  output logic [DATA_W-1:0] comp_base,
  output logic [DATA_W-1:0] regn_base,
  output logic [DATA_W-1:0] ctrl_base
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  ld_state_e                       state_q;
  logic [STEP_W-1:0]               step_q;
  logic                            beyond;
  logic                            take_rsp;
  logic                            sig_ok;
  logic [NUM_SECT-1:0][DATA_W-1:0] words;

  fdesc_step_map #(
    .ADDR_W    (ADDR_W),
    .DESC_LIMIT(DESC_LIMIT),
    .SIG_OFS   (SIG_OFS),
    .COMP_OFS  (COMP_OFS),
    .REGN_OFS  (REGN_OFS),
    .CTRL_OFS  (CTRL_OFS)
  ) u_map (
    .step  (step_q),
    .addr  (rd_req_addr),
    .beyond(beyond)
  );

  assign take_rsp = (state_q == ST_WAIT) && rd_rsp_valid;
  assign sig_ok   = (rd_rsp_data[31:0] == SIG_WORD);

  fdesc_word_bank #(
    .DATA_W(DATA_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (restart),
    .cap_en  (take_rsp && (step_q != '0)),
    .cap_sel (step_q - STEP_W'(1)),
    .cap_data(rd_rsp_data),
    .words   (words)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      state_q      <= ST_IDLE;
      step_q       <= '0;
      halt_bad_sig <= 1'b0;
      halt_range   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          step_q  <= '0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (beyond) begin
            halt_range <= 1'b1;
            state_q    <= ST_HALT;
          end else if (rd_req_ready) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rd_rsp_valid) begin
            if (step_q == '0 && !sig_ok) begin
              halt_bad_sig <= 1'b1;
              state_q      <= ST_HALT;
            end else if (step_q == LAST_STEP) begin
              state_q <= ST_DONE;
            end else begin
              step_q  <= step_q + STEP_W'(1);
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_DONE: state_q <= ST_DONE;
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign rd_req_valid = (state_q == ST_ISSUE) && !beyond;
  assign desc_valid   = (state_q == ST_DONE);
  assign halt         = (state_q == ST_HALT);
  assign comp_base    = words[0];
  assign regn_base    = words[1];
  assign ctrl_base    = words[2];
endmodule

// File: rtl/fdesc_loader_chk.sv
module fdesc_loader_chk #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DESC_LIMIT = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              desc_valid,
  input logic              halt
);
  logic outst_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) outst_q <= 1'b0;
    else if (rd_req_valid && rd_req_ready) outst_q <= 1'b1;
    else if (rd_rsp_valid) outst_q <= 1'b0;
  end

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !outst_q);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || restart)
    (rd_req_valid && !rd_req_ready) |=> (restart || (rd_req_valid && $stable(rd_req_addr))));

  assert_halt_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !rd_req_valid);

  assert_valid_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_valid && halt));

  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !restart) |=> desc_valid);

  assert_addr_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (32'(rd_req_addr) < DESC_LIMIT));

  assert_restart_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!desc_valid && !halt && !rd_req_valid));
endmodule

bind fdesc_loader fdesc_loader_chk #(
  .ADDR_W    (ADDR_W),
  .DESC_LIMIT(DESC_LIMIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .restart     (restart),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_req_addr (rd_req_addr),
  .rd_rsp_valid(rd_rsp_valid),
  .desc_valid  (desc_valid),
  .halt        (halt)
);

// File: tb/sim_fdesc_loader.sv
module sim_fdesc_loader;
  localparam logic [31:0] SIGW = 32'h0FF0_A55A;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        restart = 0;
  logic        rd_req_valid, rd_req_ready = 0;
  logic [23:0] rd_req_addr;
  logic        rd_rsp_valid = 0;
  logic [31:0] rd_rsp_data = '0;
  logic        desc_valid, halt, halt_bad_sig, halt_range;
  logic [31:0] comp_base, regn_base, ctrl_base;

  logic        q_valid, q_ready = 1, q_rsp_valid = 0, q_valid_o, q_halt, q_bad, q_rng;
  logic [23:0] q_addr;
  logic [31:0] q_rsp_data = '0, q_comp, q_regn, q_ctrl;

  int n_chk = 0, n_fail = 0;
  logic [31:0] sig_w, comp_w, regn_w, ctrl_w;
  logic [23:0] log_addr [256];
  int nlog = 0;
  bit ready_en = 0, spur_en = 0;

  always #5 clk = ~clk;

  fdesc_loader u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .desc_valid(desc_valid), .halt(halt), .halt_bad_sig(halt_bad_sig), .halt_range(halt_range),
    .comp_base(comp_base), .regn_base(regn_base), .ctrl_base(ctrl_base));

  fdesc_loader #(.CTRL_OFS(4096)) u1 (
    .clk(clk), .rst_n(rst_n), .restart(1'b0),
    .rd_req_valid(q_valid), .rd_req_ready(q_ready), .rd_req_addr(q_addr),
    .rd_rsp_valid(q_rsp_valid), .rd_rsp_data(q_rsp_data),
    .desc_valid(q_valid_o), .halt(q_halt), .halt_bad_sig(q_bad), .halt_range(q_rng),
    .comp_base(q_comp), .regn_base(q_regn), .ctrl_base(q_ctrl));

  function automatic logic [31:0] mem_rd(logic [23:0] a);
    case (a)
      24'h10:  return sig_w;
      24'h30:  return comp_w;
      24'h40:  return regn_w;
      24'h80:  return ctrl_w;
      default: return 32'hDEAD_0000 | 32'(a);
    endcase
  endfunction

  function automatic logic [23:0] exp_addr(int i);
    case (i)
      0: return 24'h10;
      1: return 24'h30;
      2: return 24'h40;
      default: return 24'h80;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Responder for u0: all stimulus changes at the falling edge
  bit pend = 0;
  logic [23:0] pend_addr;
  int lat = 0;
  initial begin
    forever begin
      @(negedge clk);
      rd_rsp_valid = 0;
      if (pend) begin
        if (lat == 0) begin
          rd_rsp_valid = 1;
          rd_rsp_data  = mem_rd(pend_addr);
          pend = 0;
        end else lat--;
      end else if (spur_en && ($urandom % 2 == 0)) begin
        rd_rsp_valid = 1;
        rd_rsp_data  = $urandom;
      end
      rd_req_ready = ready_en && ($urandom % 3 != 0);
      if (rd_req_valid && rd_req_ready && rst_n && !restart) begin
        pend = 1;
        pend_addr = rd_req_addr;
        lat = $urandom % 3;
        log_addr[nlog % 256] = rd_req_addr;
        nlog++;
      end
    end
  end

  // Responder for u1: always ready, one-cycle response
  bit pend1 = 0, bad1 = 0;
  logic [23:0] addr1;
  int cnt1 = 0;
  initial begin
    forever begin
      @(negedge clk);
      q_rsp_valid = 0;
      if (pend1) begin
        q_rsp_valid = 1;
        q_rsp_data  = mem_rd(addr1);
        pend1 = 0;
      end
      if (q_valid && rst_n) begin
        pend1 = 1;
        addr1 = q_addr;
        cnt1++;
        if (q_addr >= 24'd4096) bad1 = 1;
      end
    end
  end

  task automatic wait_end();
    for (int i = 0; i < 600; i++) begin
      if (desc_valid || halt) break;
      @(negedge clk);
    end
  endtask

  task automatic check_load(int base, string tag);
    logic good;
    good = (sig_w == SIGW);
    chk(desc_valid == good, good ? "R6" : "R4", {tag, " desc_valid"}, 32'(desc_valid), 32'(good));
    chk(halt == !good && halt_bad_sig == !good && !halt_range, "R4", {tag, " halt"},
        {29'd0, halt, halt_bad_sig, halt_range}, {29'd0, !good, !good, 1'b0});
    chk(comp_base == (good ? comp_w : 32'd0), "R5", {tag, " comp_base"}, comp_base, good ? comp_w : 32'd0);
    chk(regn_base == (good ? regn_w : 32'd0), "R5", {tag, " regn_base"}, regn_base, good ? regn_w : 32'd0);
    chk(ctrl_base == (good ? ctrl_w : 32'd0), "R6", {tag, " ctrl_base at valid"}, ctrl_base, good ? ctrl_w : 32'd0);
    repeat (20) @(negedge clk);
    chk((nlog - base) == (good ? 4 : 1), good ? "R2" : "R4", {tag, " request count"}, 32'(nlog - base), good ? 4 : 1);
    for (int i = 0; i < ((nlog - base) < 4 ? (nlog - base) : 4); i++)
      chk(log_addr[(base + i) % 256] == exp_addr(i), "R2", {tag, " request order"},
          32'(log_addr[(base + i) % 256]), 32'(exp_addr(i)));
    chk(desc_valid == good && !rd_req_valid, "R6", {tag, " sticky end state"}, 32'(desc_valid), 32'(good));
  endtask

  task automatic do_restart(string tag);
    ready_en = 0;
    @(negedge clk);
    restart = 1;
    @(negedge clk);
    restart = 0;
    chk(!desc_valid && !halt && !halt_bad_sig && !halt_range, "R8", {tag, " flags cleared"},
        {28'd0, desc_valid, halt, halt_bad_sig, halt_range}, 32'd0);
    chk(comp_base == 0 && regn_base == 0 && ctrl_base == 0, "R8", {tag, " bases cleared"},
        comp_base | regn_base | ctrl_base, 32'd0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'h5EED_0042));
    sig_w = SIGW; comp_w = 32'h1111_0030; regn_w = 32'h2222_0040; ctrl_w = 32'h3333_0080;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!rd_req_valid && !desc_valid && !halt && !halt_bad_sig && !halt_range, "R1", "reset flags",
        {27'd0, rd_req_valid, desc_valid, halt, halt_bad_sig, halt_range}, 32'd0);
    chk(comp_base == 0 && regn_base == 0 && ctrl_base == 0, "R1", "reset bases",
        comp_base | regn_base | ctrl_base, 32'd0);
    rst_n = 1;
    spur_en = 1;
    // R3 and R9: stalled request with stray responses
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      chk(rd_req_valid && rd_req_addr == 24'h10, "R3", "held request under stall",
          32'(rd_req_addr), 32'h10);
      @(negedge clk);
    end
    chk(nlog == 0 && !halt && !desc_valid, "R9", "stray responses ignored",
        {31'd0, halt | desc_valid}, 32'd0);
    // R7: second instance halts on out-of-window offset
    chk(q_halt && q_rng && !q_bad && !q_valid_o, "R7", "range halt flags",
        {28'd0, q_halt, q_rng, q_bad, q_valid_o}, 32'hC);
    chk(cnt1 == 3 && !bad1, "R7", "no out-of-window read", 32'(cnt1), 32'd3);
    chk(q_comp == comp_w && q_regn == regn_w && q_ctrl == 0, "R7", "earlier words kept",
        q_regn, regn_w);
    spur_en = 0;
    base = nlog;
    ready_en = 1;
    wait_end();
    check_load(base, "first load");

    // Directed: signature off in lowest bit
    sig_w = SIGW ^ 32'h1;
    do_restart("sig lsb");
    base = nlog; ready_en = 1; wait_end();
    check_load(base, "sig lsb flip");

    // Directed: restart in the middle of a load
    sig_w = SIGW; comp_w = 32'hA5A5_0001; regn_w = 32'h5A5A_0002; ctrl_w = 32'hFFFF_0003;
    do_restart("pre mid");
    base = nlog; ready_en = 1;
    for (int i = 0; i < 400 && (nlog - base) < 2; i++) @(negedge clk);
    do_restart("mid load");
    base = nlog; ready_en = 1; wait_end();
    check_load(base, "after mid restart");

    // Random loads, with stray responses interleaved
    for (int it = 0; it < 10; it++) begin
      comp_w = $urandom; regn_w = $urandom; ctrl_w = $urandom;
      sig_w = ($urandom % 3 == 0) ? $urandom : SIGW;
      spur_en = (it % 2 == 1);
      do_restart("random");
      base = nlog; ready_en = 1; wait_end();
      check_load(base, "random load");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule